// File: doc/BRIEF.md
# Reloadable Millisecond Interval Timer

This block raises a periodic interrupt whose spacing software sets through a reload register. A prescaler divides the system clock into one-millisecond ticks. The reload value `r` is converted into a rate of `1000 / (r + 1)` events per second, using integer division. The period, in whole milliseconds, is `1000` divided by that rate, again truncated. When the period runs out, the timer starts the next period at once and sets the interrupt line.

The interrupt stays high until software acknowledges it. A read of the count register acknowledges it and always returns zero. A write to the reload register also lowers the line and starts a fresh period from the clock edge of the write. A reload value of 1000 or more gives a rate of zero, and the timer then stays idle until a smaller value is written.

The register port is a plain single-cycle strobe interface with 32-bit data. There is no data stream here, so no valid/ready handshake is used. A write is taken on the edge where `bus_wr` is high. A read has its side effect on the edge where `bus_rd` is high. `bus_rdata` is combinational from `bus_addr` and `bus_rd`.

Top module: `ms_interval_timer`

## Requirements
- R1: With reload value `r` below 1000, let `f = 1000/(r+1)` and `P = 1000/f` (both integer division). The interrupt rises exactly `P*CYCLES_PER_MS` clock edges after the edge that started the period. For example, r=0 gives P=1, r=2 gives P=3 and r=999 gives P=1000.
- R2: A write to the reload register (byte offset 0x0) stores `bus_wdata`, drives `irq` low after that edge and restarts the period from that edge. This holds even when the write falls on the same edge as an expiry.
- R3: A read of the count register (byte offset 0x4) returns 0 on `bus_rdata` and drives `irq` low after that edge.
- R4: After an expiry the next period starts without software action, so the next rise follows `P*CYCLES_PER_MS` edges after the expiry edge. Between expiries `irq` holds its level until it is cleared.
- R5: After reset the reload value reads 0, `irq` is low, and the first rise comes `CYCLES_PER_MS` edges after reset is released.
- R6: With a reload value of 1000 or more, including 0xFFFFFFFF, `irq` never rises until a value below 1000 is written.
- R7: When a count read falls on the same edge as an expiry, `irq` stays low and the new period still starts at that edge.
- R8: A read of offset 0x0 returns the stored reload value with no side effect. A read of any other offset except 0x4 returns 0. A write to any offset other than 0x0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt, high after expiry until cleared |

## Verification
The hardest case to reach from the ports is a count read or a reload write that falls on exactly the same edge as an expiry. The rise is counted from the restart edge, and the access strobe is placed on edge `P*CYCLES_PER_MS` so that both events collide. The bench then checks that `irq` stays low and that the following rise is one full period later. Random reload values, some of them in the stopped range, cover the period arithmetic at many points, including the truncation cases where `1000/f` is not exact.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned MS_PER_SEC = 1000;
  localparam int unsigned MS_W       = 11;     // holds periods up to 1000 ms
  localparam int unsigned OFS_RELOAD = 'h0;
  localparam int unsigned OFS_COUNT  = 'h4;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned CYCLES_PER_MS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned PRE_W = $clog2(CYCLES_PER_MS + 1);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CYCLES_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = run && !restart && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (restart || !run)    pre_q <= '0;
    else if (pre_q == LAST)      pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ivt_period_calc.sv
module ivt_period_calc
  import ivt_pkg::*;
(
  input  logic [DATA_W-1:0] reload,
  output logic [MS_W-1:0]   period_ms,
  output logic              stopped
);
  logic [MS_W-1:0] divisor;
  logic [MS_W-1:0] rate;

  always_comb begin
    stopped   = (reload >= DATA_W'(MS_PER_SEC));
    divisor   = MS_W'(reload[MS_W-1:0]) + 1'b1;
    rate      = '0;
    period_ms = MS_W'(1);
    if (!stopped) begin
      rate = MS_W'(MS_PER_SEC) / divisor;
      if (rate != '0) period_ms = MS_W'(MS_PER_SEC) / rate;
    end
  end
endmodule

// File: rtl/ivt_period_counter.sv
module ivt_period_counter
  import ivt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic            tick,
  input  logic [MS_W-1:0] period_ms,
  output logic            expire,
  output logic [MS_W-1:0] ms_cnt
);
  assign expire = tick && (ms_cnt == period_ms - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ms_cnt <= '0;
    else if (restart || !run)  ms_cnt <= '0;
    else if (expire)           ms_cnt <= '0;
    else if (tick)             ms_cnt <= ms_cnt + 1'b1;
  end
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 250000,
  parameter int unsigned ADDR_W        = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);

  logic [DATA_W-1:0] reload_q;
  logic [MS_W-1:0]   period_ms;
  logic [MS_W-1:0]   ms_cnt;
  logic              stopped;
  logic              tick;
  logic              expire;
  logic              wr_reload;
  logic              rd_count;

  assign wr_reload = bus_wr && (bus_addr == A_RELOAD);
  assign rd_count  = bus_rd && (bus_addr == A_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= bus_wdata;
  end

  ivt_period_calc u_calc (
    .reload    (reload_q),
    .period_ms (period_ms),
    .stopped   (stopped)
  );

  ivt_prescaler #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_reload),
    .run     (!stopped),
    .tick    (tick)
  );

  ivt_period_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (wr_reload),
    .run       (!stopped),
    .tick      (tick),
    .period_ms (period_ms),
    .expire    (expire),
    .ms_cnt    (ms_cnt)
  );

  // clear from either access beats a coincident expiry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq <= 1'b0;
    else if (wr_reload || rd_count)  irq <= 1'b0;
    else if (expire)                 irq <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && bus_addr == A_RELOAD) bus_rdata = reload_q;
  end
endmodule

// File: rtl/ms_interval_timer_chk.sv
module ms_interval_timer_chk
  import ivt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick,
  input logic              stopped,
  input logic [MS_W-1:0]   ms_cnt,
  input logic [MS_W-1:0]   period_ms
);
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |-> (ms_cnt < period_ms));

  a_r2_write_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_RELOAD)) |=> !irq);

  a_r3_read_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_COUNT)) |=> !irq);

  a_r3_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_COUNT)) |-> (bus_rdata == '0));

  a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));

  a_r6_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !$rose(irq));
endmodule

bind ms_interval_timer ms_interval_timer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ms_interval_timer_bench.sv
`timescale 1ns/1ps
module ms_interval_timer_bench;
  localparam int unsigned CPM    = 4;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] A_RELOAD = 'h0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 'h4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ms_interval_timer #(.CYCLES_PER_MS(CPM), .ADDR_W(ADDR_W)) u_ms_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // edges from restart to rise; 0 means the timer is stopped
  function automatic int unsigned exp_edges(input logic [31:0] r);
    int unsigned f;
    if (r >= 32'd1000) return 0;
    f = 1000 / (r + 1);
    return (1000 / f) * CPM;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // called at the negedge right after the restart edge
  task automatic expect_window(input int unsigned t, input string tag);
    check(irq == 1'b0, {tag, " low after restart"}, irq, 0);
    repeat (t - 1) @(negedge clk);
    check(irq == 1'b0, {tag, " low one edge before expiry"}, irq, 0);
    @(negedge clk);
    check(irq == 1'b1, {tag, " high at expiry"}, irq, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int unsigned t;
    bit saw;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: reset state and 1 ms first period
    expect_window(CPM, "R5");
    do_read(A_RELOAD, rd);
    check(rd == 32'd0, "R5 reload after reset", rd, 0);
    check(irq == 1'b1, "R8 reload read has no side effect", irq, 1);
    // R3: count read returns zero and clears
    do_read(A_COUNT, rd);
    check(rd == 32'd0, "R3 count reads zero", rd, 0);
    check(irq == 1'b0, "R3 count read clears", irq, 0);
    // R8: stray accesses
    do_write('h8, 32'd77);
    do_read(A_RELOAD, rd);
    check(rd == 32'd0, "R8 stray write ignored", rd, 0);
    do_read('h8, rd);
    check(rd == 32'd0, "R8 stray read zero", rd, 0);
    // R2/R1: write reload 1 -> 2 ms
    do_write(A_RELOAD, 32'd1);
    t = exp_edges(32'd1);
    expect_window(t, "R1 r=1");
    // R4: clear one edge after expiry, next rise one period after expiry
    do_read(A_COUNT, rd);
    check(irq == 1'b0, "R4 cleared", irq, 0);
    repeat (t - 2) @(negedge clk);
    check(irq == 1'b0, "R4 low before second expiry", irq, 0);
    @(negedge clk);
    check(irq == 1'b1, "R4 auto restart rise", irq, 1);
    // R7: count read on the expiry edge
    do_write(A_RELOAD, 32'd2);
    t = exp_edges(32'd2);
    repeat (t - 1) @(negedge clk);
    do_read(A_COUNT, rd);
    expect_window(t, "R7");
    // R2: reload write on the expiry edge
    do_write(A_RELOAD, 32'd0);
    repeat (CPM - 1) @(negedge clk);
    do_write(A_RELOAD, 32'd6);
    expect_window(exp_edges(32'd6), "R2 write at expiry");
    // R6: stopped values
    do_write(A_RELOAD, 32'd1000);
    saw = 1'b0;
    repeat (3000) begin @(negedge clk); if (irq) saw = 1'b1; end
    check(!saw, "R6 reload 1000 stays quiet", saw, 0);
    do_read(A_RELOAD, rd);
    check(rd == 32'd1000, "R8 reload readback", rd, 32'd1000);
    do_write(A_RELOAD, 32'hFFFF_FFFF);
    saw = 1'b0;
    repeat (2000) begin @(negedge clk); if (irq) saw = 1'b1; end
    check(!saw, "R6 reload all-ones stays quiet", saw, 0);
    do_write(A_RELOAD, 32'd999);
    expect_window(exp_edges(32'd999), "R1 r=999");
    // R1 random reload values
    for (int i = 0; i < 14; i++) begin
      logic [31:0] r;
      r = ($urandom % 2) ? ($urandom % 40) : ($urandom % 1100);
      do_write(A_RELOAD, r);
      t = exp_edges(r);
      if (t == 0) begin
        saw = 1'b0;
        repeat (1500) begin @(negedge clk); if (irq) saw = 1'b1; end
        check(!saw, "R6 random stopped value", saw, 0);
      end else begin
        expect_window(t, "R1 random");
      end
    end
    finish_run();
  end
endmodule